// File: doc/BRIEF.md
# Timer Channel with Selectable Counting Clock

This block is a single timer channel for a peripheral subsystem. A 16-bit up-counter runs entirely in the system clock domain. It advances once for each validated edge of a counting source chosen from eight options. Five options are fixed ratios of the system clock, produced as one-cycle enable pulses by a free-running divider. The other three are external clock pins, which are brought into the system clock domain through a two-stage synchronizer and then edge-detected.

The chosen source can be counted on its falling edge instead of its rising edge. Counting can also be gated by the synchronized level of one of the external pins, which lets a slow enable signal open and close a counting window. Software can request a reset of the count with a trigger pulse. The reset is applied on the next valid counting edge, so the count never jumps while the counting clock is idle. A sticky overflow flag records a wrap from all-ones to zero and clears when the status is read. External sources must hold each level for more than one system clock period and run at no more than 1/2.5 of the system clock frequency.

Top module: `tmr_chan`

## Requirements
- R1: After reset the count is 0, the overflow flag is 0 and the configuration is 0, which selects divide-by-2 with rising-edge counting and no gating.
- R2: The count rises by exactly one on each valid counting edge and holds its value in every other cycle. It is visible on `cnt_val` in every cycle without stopping the count.
- R3: Clock-select values 0, 1, 2, 3 and 4 select the system clock divided by 2, 8, 32, 128 and 1024. A divider counts system cycles from 0 after reset. For ratio N, the rising edge is valid in the cycle where the divider modulo N equals N/2-1, and the count changes at the end of that cycle.
- R4: Clock-select values 5, 6 and 7 select `xc_in[0]`, `xc_in[1]` and `xc_in[2]`. A pin level first sampled at clock edge k is seen by a two-flop synchronizer, and the resulting count change appears at edge k+2.
- R5: With the invert bit set, the count advances on falling edges instead. For an internal source this is the cycle where the divider modulo N equals N-1. For an external source it is a high-to-low change of the synchronized level.
- R6: Burst field 0 disables gating. Values 1, 2 and 3 gate counting with the synchronized level of `xc_in[0]`, `xc_in[1]` and `xc_in[2]`. A valid edge counts only if that level is high in the same cycle; otherwise the count holds.
- R7: A one-cycle `sw_trig` pulse makes the count 0 at the next valid counting edge, including an edge in the same cycle. The count is unchanged until that edge, and that edge never sets the overflow flag.
- R8: A valid edge that takes the count from 0xFFFF to 0x0000, with no pending trigger, sets `ovf_sts` at that edge. The flag then stays set until it is read.
- R9: A cycle with `stat_rd` high clears `ovf_sts` at the following edge. If an overflow occurs in that same cycle, the flag stays set.
- R10: With `cfg_we` high, `cfg_wdata` is stored at the clock edge and takes effect from the next cycle. Its fields are: clock select in bits [2:0], invert in bit [3], burst in bits [5:4]. `cfg_rdata` returns the stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Configuration write value (select, invert, burst) |
| cfg_rdata | output | 6 | Stored configuration |
| sw_trig | input | 1 | Software trigger, resets count on next valid edge |
| stat_rd | input | 1 | Status read strobe, clears overflow flag |
| xc_in | input | 3 | External clock / gating inputs, asynchronous |
| cnt_val | output | 16 | Live counter value |
| ovf_sts | output | 1 | Sticky overflow flag |

## Verification
For an internal source, the count changes at the clock edge that closes the divider cycle named in R3 or R5. For an external pin, the change comes at the third edge after the pin is driven: two synchronizer stages plus the counter register. A configuration write, a status-read clear and a trigger all act at the first edge after their strobe, and a trigger's effect then waits for a counting edge. The bench drives every input on the falling clock edge. Its behavioural model advances on the rising edge by these same latencies. Outputs are compared with the model on each falling edge, and the directed checks wait the exact number of falling edges given above before they sample.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // Number of divided internal sources and external pins
   localparam int NUM_INT = 5;
   localparam int NUM_EXT = 3;
   localparam int NUM_SRC = NUM_INT + NUM_EXT;
   localparam int SEL_W   = $clog2(NUM_SRC);
   localparam int BURST_W = $clog2(NUM_EXT + 1);

   // Configuration word: burst [5:4], invert [3], select [2:0]
   typedef struct packed {
      logic [BURST_W-1:0] burst;
      logic               inv;
      logic [SEL_W-1:0]   clk_sel;
   } tmr_cfg_t;

   localparam int CFG_W = $bits(tmr_cfg_t);

   // log2 of the division ratio of internal source idx (2,8,32,128,1024)
   function automatic int div_log2(input int idx);
      case (idx)
         0:       return 1;
         1:       return 3;
         2:       return 5;
         3:       return 7;
         default: return 10;
      endcase
   endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
   import tmr_pkg::*;
#(
   parameter int DIV_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [NUM_INT-1:0] rise_en,
   output logic [NUM_INT-1:0] fall_en
);

   if (DIV_W < div_log2(NUM_INT - 1)) begin : g_bad_div_w
      $error("tmr_prescale: DIV_W too small for largest ratio");
   end

   logic [DIV_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 1'b1;
   end

   // Divided square wave of ratio 2^K is div_q[K-1]; its rising edge
   // follows the cycle with low bits 0111.., its falling edge 1111..
   for (genvar i = 0; i < NUM_INT; i++) begin : g_tap
      localparam int K = div_log2(i);
      localparam logic [K-1:0] RISE_PT = K'((1 << (K - 1)) - 1);
      assign rise_en[i] = (div_q[K-1:0] == RISE_PT);
      assign fall_en[i] = &div_q[K-1:0];
   end

endmodule

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync #(
   parameter int N_IN   = 3,
   parameter int STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_IN-1:0] ext_in,
   output logic [N_IN-1:0] lvl,
   output logic [N_IN-1:0] rise,
   output logic [N_IN-1:0] fall
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_ext_sync: at least two synchronizer stages required");
   end

   for (genvar i = 0; i < N_IN; i++) begin : g_pin
      // STAGES synchronizer flops plus one history flop for edge detect
      logic [STAGES:0] sh_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= {sh_q[STAGES-1:0], ext_in[i]};
      end

      assign lvl[i]  = sh_q[STAGES-1];
      assign rise[i] = sh_q[STAGES-1] & ~sh_q[STAGES];
      assign fall[i] = ~sh_q[STAGES-1] & sh_q[STAGES];
   end

endmodule

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
   import tmr_pkg::*;
(
   input  tmr_cfg_t           cfg,
   input  logic [NUM_INT-1:0] int_rise,
   input  logic [NUM_INT-1:0] int_fall,
   input  logic [NUM_EXT-1:0] ext_rise,
   input  logic [NUM_EXT-1:0] ext_fall,
   input  logic [NUM_EXT-1:0] ext_lvl,
   output logic               gate_ok,
   output logic               cnt_en
);

   if (NUM_SRC > (1 << SEL_W)) begin : g_bad_sel
      $error("tmr_clk_sel: select field cannot address all sources");
   end

   logic [NUM_SRC-1:0] src_rise;
   logic [NUM_SRC-1:0] src_fall;
   logic [NUM_EXT:0]   gate_vec;
   logic               edge_pick;

   // Internal sources occupy the low select codes, pins the upper ones
   assign src_rise = {ext_rise, int_rise};
   assign src_fall = {ext_fall, int_fall};

   // Burst code 0 is always open; code n follows pin n-1
   assign gate_vec = {ext_lvl, 1'b1};

   always_comb begin
      edge_pick = 1'b0;
      if (32'(cfg.clk_sel) < NUM_SRC) begin
         edge_pick = cfg.inv ? src_fall[cfg.clk_sel] : src_rise[cfg.clk_sel];
      end
   end

   assign gate_ok = gate_vec[cfg.burst];
   assign cnt_en  = edge_pick & gate_ok;

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             sw_trig,
   input  logic             stat_rd,
   output logic [CNT_W-1:0] cnt_val,
   output logic             ovf_sts,
   output logic             rst_req,
   output logic             ovf_set
);

   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("tmr_count: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             pend_q;
   logic             ovf_q;

   // A trigger is held until a counting edge consumes it
   assign rst_req = pend_q | sw_trig;
   assign ovf_set = cnt_en & ~rst_req & (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         if (cnt_en) cnt_q <= rst_req ? '0 : cnt_q + 1'b1;
         pend_q <= rst_req & ~cnt_en;
         ovf_q  <= ovf_set | (ovf_q & ~stat_rd);
      end
   end

   assign cnt_val = cnt_q;
   assign ovf_sts = ovf_q;

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int DIV_W       = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [CFG_W-1:0]   cfg_wdata,
   output logic [CFG_W-1:0]   cfg_rdata,
   input  logic               sw_trig,
   input  logic               stat_rd,
   input  logic [NUM_EXT-1:0] xc_in,
   output logic [CNT_W-1:0]   cnt_val,
   output logic               ovf_sts
);

   tmr_cfg_t           cfg_q;
   logic [NUM_INT-1:0] int_rise;
   logic [NUM_INT-1:0] int_fall;
   logic [NUM_EXT-1:0] ext_lvl;
   logic [NUM_EXT-1:0] ext_rise;
   logic [NUM_EXT-1:0] ext_fall;
   logic               gate_ok;
   logic               cnt_en;
   logic               rst_req;
   logic               ovf_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (cfg_we) cfg_q <= tmr_cfg_t'(cfg_wdata);
   end

   assign cfg_rdata = cfg_q;

   tmr_prescale #(
      .DIV_W (DIV_W)
   ) u_prescale (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise_en (int_rise),
      .fall_en (int_fall)
   );

   tmr_ext_sync #(
      .N_IN   (NUM_EXT),
      .STAGES (SYNC_STAGES)
   ) u_ext_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .ext_in (xc_in),
      .lvl    (ext_lvl),
      .rise   (ext_rise),
      .fall   (ext_fall)
   );

   tmr_clk_sel u_clk_sel (
      .cfg      (cfg_q),
      .int_rise (int_rise),
      .int_fall (int_fall),
      .ext_rise (ext_rise),
      .ext_fall (ext_fall),
      .ext_lvl  (ext_lvl),
      .gate_ok  (gate_ok),
      .cnt_en   (cnt_en)
   );

   tmr_count #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_en  (cnt_en),
      .sw_trig (sw_trig),
      .stat_rd (stat_rd),
      .cnt_val (cnt_val),
      .ovf_sts (ovf_sts),
      .rst_req (rst_req),
      .ovf_set (ovf_set)
   );

endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt_val,
   input logic             ovf_sts,
   input logic             stat_rd,
   input logic             cnt_en,
   input logic             rst_req,
   input logic             ovf_set
);

   AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> $stable(cnt_val)); // R2

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && !rst_req) |=> cnt_val == CNT_W'($past(cnt_val) + 1'b1)); // R2

   AST_TRIG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && rst_req) |=> cnt_val == '0); // R7

   AST_TRIG_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req && !cnt_en) |=> $stable(cnt_val)); // R7

   AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && !rst_req && (&cnt_val)) |=> (ovf_sts && cnt_val == '0)); // R8

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_sts && !stat_rd) |=> ovf_sts); // R8

   AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !ovf_set) |=> !ovf_sts); // R9

endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cnt_val (cnt_val),
   .ovf_sts (ovf_sts),
   .stat_rd (stat_rd),
   .cnt_en  (cnt_en),
   .rst_req (rst_req),
   .ovf_set (ovf_set)
);

// File: tb/test_tmr_chan.sv
`timescale 1ns/100ps
module test_tmr_chan;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_wdata = '0;
   logic [5:0]  cfg_rdata;
   logic        sw_trig = 1'b0;
   logic        stat_rd = 1'b0;
   logic [2:0]  xc_in;
   logic [15:0] cnt_val;
   logic        ovf_sts;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   tmr_chan i_tmr_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .sw_trig   (sw_trig),
      .stat_rd   (stat_rd),
      .xc_in     (xc_in),
      .cnt_val   (cnt_val),
      .ovf_sts   (ovf_sts)
   );

   // ---------------- external pin generator ----------------
   int hp[3] = '{0, 0, 0};       // half period in cycles, 0 = hold
   bit hold_v[3] = '{0, 0, 0};
   bit gen_v[3] = '{0, 0, 0};
   int gen_c[3] = '{0, 0, 0};

   always @(negedge clk) begin
      for (int i = 0; i < 3; i++) begin
         if (hp[i] != 0) begin
            if (gen_c[i] >= hp[i] - 1) begin
               gen_c[i] = 0;
               gen_v[i] = !gen_v[i];
            end else gen_c[i] = gen_c[i] + 1;
         end
      end
   end

   always_comb begin
      for (int i = 0; i < 3; i++) xc_in[i] = (hp[i] == 0) ? hold_v[i] : gen_v[i];
   end

   // ---------------- behavioural reference model ----------------
   int          divs[5] = '{2, 8, 32, 128, 1024};
   int          m_d;
   bit [2:0]    m_s1, m_s2, m_sp;
   bit [15:0]   m_cnt;
   bit          m_pend, m_ovf;
   bit [5:0]    m_cfg;

   always @(posedge clk or negedge rst_n) begin : mdl
      int sel, bs, nr, e;
      bit inv, edge_ok, gate, en, req, wrap;
      if (!rst_n) begin
         m_d = 0; m_s1 = 0; m_s2 = 0; m_sp = 0;
         m_cnt = 0; m_pend = 0; m_ovf = 0; m_cfg = 0;
      end else begin
         sel = int'(m_cfg[2:0]);
         inv = m_cfg[3];
         bs  = int'(m_cfg[5:4]);
         if (sel < 5) begin
            nr = divs[sel];
            edge_ok = inv ? ((m_d % nr) == nr - 1) : ((m_d % nr) == nr / 2 - 1);
         end else begin
            e = sel - 5;
            edge_ok = inv ? (!m_s2[e] && m_sp[e]) : (m_s2[e] && !m_sp[e]);
         end
         gate = (bs == 0) ? 1'b1 : m_s2[bs-1];
         en   = edge_ok && gate;
         req  = m_pend || sw_trig;
         wrap = en && !req && (m_cnt == 16'hFFFF);
         if (en) m_cnt = req ? 16'h0 : m_cnt + 16'h1;
         m_pend = req && !en;
         m_ovf  = wrap || (m_ovf && !stat_rd);
         m_sp = m_s2; m_s2 = m_s1; m_s1 = xc_in;
         m_d  = (m_d + 1) % 1024;
         if (cfg_we) m_cfg = cfg_wdata;
      end
   end

   // ---------------- checking ----------------
   task automatic check(input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   bit cmp_on = 1'b0;
   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         check(cur_req, "cnt_val", int'(cnt_val), int'(m_cnt));
         check(cur_req, "ovf_sts", int'(ovf_sts), int'(m_ovf));
         check(cur_req, "cfg_rdata", int'(cfg_rdata), int'(m_cfg));
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg_write(input int sel, input int inv, input int bs);
      logic [5:0] v;
      v = {2'(bs), 1'(inv), 3'(sel)};
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
      check("R10", "cfg_rdata", int'(cfg_rdata), int'(v));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin : stim
      int c;
      cycles(5);
      check("R1", "cnt_val", int'(cnt_val), 0);
      check("R1", "ovf_sts", int'(ovf_sts), 0);
      check("R1", "cfg_rdata", int'(cfg_rdata), 0);
      rst_n = 1'b1;
      cmp_on = 1'b1;

      // R3 / R8 / R9: divide-by-2 default runs until the wrap
      cur_req = "R3";
      cycles(100);
      cur_req = "R8";
      do @(negedge clk); while (!(m_cnt == 16'hFFFF && (m_d % 2) == 0));
      stat_rd = 1'b1;                 // read in the wrap cycle
      @(negedge clk);
      stat_rd = 1'b0;
      check("R9", "ovf kept on same-cycle read", int'(ovf_sts), 1);
      check("R8", "count wrapped", int'(cnt_val), 0);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         check("R8", "ovf sticky", int'(ovf_sts), 1);
      end
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
      check("R9", "ovf cleared by read", int'(ovf_sts), 0);

      // R3 / R5: every internal ratio, both edges
      for (int s = 1; s < 5; s++) begin
         for (int v = 0; v < 2; v++) begin
            cur_req = (v == 0) ? "R3" : "R5";
            cfg_write(s, v, 0);
            cycles(divs[s] * 2 + 20);
         end
      end

      // R7: trigger waits for the next divide-by-1024 edge
      cur_req = "R7";
      cfg_write(4, 0, 0);
      do @(negedge clk); while ((m_d % 1024) != 600);
      c = int'(cnt_val);
      sw_trig = 1'b1;
      @(negedge clk);
      sw_trig = 1'b0;
      check("R7", "count held after trigger", int'(cnt_val), c);
      do @(negedge clk); while ((m_d % 1024) != 512);
      check("R7", "count zero at next edge", int'(cnt_val), 0);

      // R7: trigger in the same cycle as a divide-by-2 edge
      cfg_write(0, 0, 0);
      cycles(30);
      do @(negedge clk); while ((m_d % 2) != 0);
      sw_trig = 1'b1;
      @(negedge clk);
      sw_trig = 1'b0;
      check("R7", "same-cycle trigger", int'(cnt_val), 0);
      cycles(10);

      // R4: external pin latency
      cur_req = "R4";
      hp[0] = 0; hold_v[0] = 1'b0;
      cfg_write(5, 0, 0);
      cycles(6);
      c = int'(cnt_val);
      hold_v[0] = 1'b1;
      @(negedge clk);
      check("R4", "no change after 1 edge", int'(cnt_val), c);
      @(negedge clk);
      check("R4", "no change after 2 edges", int'(cnt_val), c);
      @(negedge clk);
      check("R4", "increment at 3rd edge", int'(cnt_val), c + 1);

      // R4 / R5: toggling pins, both polarities
      hp[0] = 2; hp[1] = 3; hp[2] = 5;
      for (int s = 5; s < 8; s++) begin
         for (int v = 0; v < 2; v++) begin
            cur_req = (v == 0) ? "R4" : "R5";
            cfg_write(s, v, 0);
            cycles(200);
         end
      end

      // R6: gating closed holds the count
      cur_req = "R6";
      hp[0] = 0; hold_v[0] = 1'b0;
      cfg_write(0, 0, 1);
      cycles(5);
      c = int'(cnt_val);
      cycles(20);
      check("R6", "gated count holds", int'(cnt_val), c);

      // R6: gating by each pin while it toggles slowly
      hp[0] = 7; hp[1] = 11; hp[2] = 13;
      for (int b = 1; b < 4; b++) begin
         cfg_write(0, 0, b);
         cycles(300);
      end
      cfg_write(2, 1, 3);
      cycles(300);

      cmp_on = 1'b0;
      finish_run();
   end

endmodule